// File: doc/BRIEF.md
# Serial Configuration Port with Status Reply

This block is a four-wire serial slave that lets a host controller read and write a bank of byte-wide configuration registers. The host lowers chip select, then shifts in a header byte that selects the direction, single or burst access, and a start address. While that header shifts in, the block shifts out a status byte. The status byte carries a not-ready flag, the core's three-bit main-state code and a FIFO fill count. The fill count shows bytes waiting in the receive FIFO when the header asks for a read, and free space in the transmit FIFO when it asks for a write.

The serial pins are brought into the block clock domain through synchronisers, and all transfer logic runs on that clock. Register contents are presented to the core as one flat vector. On a write, every data byte gets a fresh status byte back. On a read, register data is returned after the header. In a burst, an internal address counter steps after each data byte.

Top module: `spi_reg_if`

## Requirements
- R1: Each header byte returns a status byte, MSB first. Bit 7 is the inverse of `ready_i`. Bits 6:4 are `state_i`: 0 idle, 1 receive, 2 transmit, 3 fast-transmit-ready, 4 calibrate, 5 settling, 6 receive overflow, 7 transmit underflow. Both are taken when the status byte is loaded, which is at the chip-select fall or at the end of the previous byte.
- R2: Status bits 3:0 follow the first header bit. If that bit is 1, they give `rx_level_i`; if it is 0, they give `tx_free_i`. Any level of 15 or above reads as 15.
- R3: Header layout: bit 7 is 1 for read and 0 for write, bit 6 selects burst, bits 5:0 are the start address.
- R4: The bus uses mode 0. SI is taken on the rising SCLK edge. SO changes only after a falling SCLK edge or the chip-select fall, and it holds while SCLK is high.
- R5: There are 47 registers, at addresses 0x00 to 0x2E, each readable and writable. A write data byte is stored at the current address. Each write data byte returns a status byte whose count is the transmit free level.
- R6: In a read, each data slot returns the register at the current address. Addresses 0x2F to 0x3F return 0x00.
- R7: In a burst, the address counter steps by one after each data byte. From 0x2E or above, it steps to 0x00.
- R8: A non-burst access carries exactly one data byte. The byte after it is taken as a new header and returns a new status byte.
- R9: A write to an address above 0x2E changes no register.
- R10: Raising chip select ends the transfer. A partly shifted byte is dropped without a write, and the next transfer starts with a header.
- R11: Changes to `ready_i`, `state_i`, `rx_level_i` or `tx_free_i` while a header is shifting do not alter that header's status byte.
- R12: After reset, SO is low and every register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, at least 8x SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| ready_i | input | 1 | Core power and clock source stable |
| state_i | input | 3 | Core main-state code |
| rx_level_i | input | CNT_W | Receive FIFO bytes available |
| tx_free_i | input | CNT_W | Transmit FIFO bytes free |
| cfg_regs_o | output | NUM_REGS*8 | Register bank, register n at bits n*8+7:n*8 |

## Verification
Two things can happen during one header byte: the core changes its state and FIFO levels, and the block shifts out the status snapshot it took at the start of that byte. The bench provokes this by changing all four status inputs halfway through selected headers, both in directed cases and at random. It judges the reply against a status value computed from the inputs as they were before the change. The same collision shows up at the end of a burst write, where a write, an address wrap to 0x00 and a new status load all land within one byte boundary. That case is judged against a register model that steps its own address counter.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RX     = 3'd1,
    ST_TX     = 3'd2,
    ST_FSTX   = 3'd3,
    ST_CAL    = 3'd4,
    ST_SETTLE = 3'd5,
    ST_RX_OVF = 3'd6,
    ST_TX_UNF = 3'd7
  } core_state_e;

  typedef struct packed {
    logic        not_rdy;
    core_state_e state;
    logic [3:0]  cnt;
  } status_t;

  typedef struct packed {
    logic              rd;
    logic              burst;
    logic [ADDR_W-1:0] addr;
  } hdr_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int unsigned STAGES = 2  // minimum 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic csn_o,
  output logic csn_fall_o,
  output logic si_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] sclk_q, csn_q, si_q;
  logic sclk_d, csn_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      csn_q  <= '1;
      si_q   <= '0;
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      csn_q  <= {csn_q[STAGES-2:0], csn_i};
      si_q   <= {si_q[STAGES-2:0], si_i};
      sclk_d <= sclk_q[TOP];
      csn_d  <= csn_q[TOP];
    end
  end

  assign sclk_rise_o = sclk_q[TOP] & ~sclk_d;
  assign sclk_fall_o = ~sclk_q[TOP] & sclk_d;
  assign csn_o       = csn_q[TOP];
  assign csn_fall_o  = ~csn_q[TOP] & csn_d;
  assign si_o        = si_q[TOP];
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank #(
  parameter int unsigned NUM_REGS = 47,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we_i && waddr_i <= LAST_ADDR) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i <= LAST_ADDR) ? mem[raddr_i] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = mem[g];
  end

  assert_wr_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i > LAST_ADDR) |=> $stable(regs_o));
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 47,
  parameter int unsigned CNT_W    = 7   // minimum 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              csn_i,
  input  logic              csn_fall_i,
  input  logic              si_i,
  input  logic              not_rdy_i,
  input  core_state_e       state_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              so_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] raddr_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  function automatic logic [3:0] sat4(input logic [CNT_W-1:0] c);
    return (c >= CNT_W'(15)) ? 4'hF : c[3:0];
  endfunction

  logic [BIT_W-1:0]  bit_cnt;
  logic              in_hdr, load_pend;
  logic              rd_q, burst_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        rx_snap, tx_snap;
  logic [BYTE_W-2:0] sh_in;
  logic [BYTE_W-1:0] sh_out;
  logic              we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [BYTE_W-1:0] wdata_q;

  hdr_t              hdr_in;
  logic [BYTE_W-1:0] byte_in;
  status_t           hdr_st, wr_st;
  logic [BYTE_W-1:0] next_out;
  logic [ADDR_W-1:0] next_addr;

  assign byte_in   = {sh_in, si_i};
  assign hdr_in    = hdr_t'(byte_in);
  assign hdr_st    = '{not_rdy: not_rdy_i, state: state_i, cnt: 4'h0};
  assign wr_st     = '{not_rdy: not_rdy_i, state: state_i, cnt: sat4(tx_cnt_i)};
  assign next_out  = in_hdr ? BYTE_W'(hdr_st) : (rd_q ? rdata_i : BYTE_W'(wr_st));
  assign next_addr = (addr_q >= LAST_ADDR) ? '0 : addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      in_hdr    <= 1'b1;
      load_pend <= 1'b0;
      rd_q      <= 1'b0;
      burst_q   <= 1'b0;
      addr_q    <= '0;
      rx_snap   <= '0;
      tx_snap   <= '0;
      sh_in     <= '0;
      sh_out    <= '0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (csn_i) begin
        bit_cnt   <= '0;
        in_hdr    <= 1'b1;
        load_pend <= 1'b0;
        rd_q      <= 1'b0;
        burst_q   <= 1'b0;
      end else if (csn_fall_i) begin
        sh_out  <= BYTE_W'(hdr_st);
        rx_snap <= sat4(rx_cnt_i);
        tx_snap <= sat4(tx_cnt_i);
      end else if (sclk_rise_i) begin
        sh_in   <= byte_in[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        // direction bit arrives first: fill the count field before it shifts out
        if (in_hdr && bit_cnt == '0) sh_out[3:0] <= si_i ? rx_snap : tx_snap;
        if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
          load_pend <= 1'b1;
          if (in_hdr) begin
            rd_q    <= hdr_in.rd;
            burst_q <= hdr_in.burst;
            addr_q  <= hdr_in.addr;
            in_hdr  <= 1'b0;
          end else begin
            if (!rd_q) begin
              we_q    <= 1'b1;
              waddr_q <= addr_q;
              wdata_q <= byte_in;
            end
            if (burst_q) addr_q <= next_addr;
            else         in_hdr <= 1'b1;
          end
        end
      end else if (sclk_fall_i) begin
        if (load_pend) begin
          load_pend <= 1'b0;
          sh_out    <= next_out;
          if (in_hdr) begin
            rx_snap <= sat4(rx_cnt_i);
            tx_snap <= sat4(tx_cnt_i);
          end
        end else begin
          sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign so_o    = sh_out[BYTE_W-1];
  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;
  assign raddr_o = addr_q;

  assert_so_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_fall_i && !csn_fall_i) |=> $stable(so_o));

  assert_csn_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csn_i) |=> (in_hdr && bit_cnt == '0 && !burst_q));

  assert_we_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> !rd_q);

  assert_we_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);

  assert_snap_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csn_fall_i && !(sclk_fall_i && load_pend)) |=> ($stable(rx_snap) && $stable(tx_snap)));
endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if
  import spi_reg_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 47,
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       csn_i,
  input  logic                       si_i,
  output logic                       so_o,
  input  logic                       ready_i,
  input  logic [2:0]                 state_i,
  input  logic [CNT_W-1:0]           rx_level_i,
  input  logic [CNT_W-1:0]           tx_free_i,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_regs_o
);
  logic sclk_rise, sclk_fall, csn_s, csn_fall, si_s;
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [BYTE_W-1:0] wdata, rdata;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .csn_i       (csn_i),
    .si_i        (si_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .csn_o       (csn_s),
    .csn_fall_o  (csn_fall),
    .si_o        (si_s)
  );

  spi_frame_ctrl #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .csn_i       (csn_s),
    .csn_fall_i  (csn_fall),
    .si_i        (si_s),
    .not_rdy_i   (~ready_i),
    .state_i     (core_state_e'(state_i)),
    .rx_cnt_i    (rx_level_i),
    .tx_cnt_i    (tx_free_i),
    .rdata_i     (rdata),
    .so_o        (so_o),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .raddr_o     (raddr)
  );

  spi_cfg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .regs_o  (cfg_regs_o)
  );
endmodule

// File: tb/spi_reg_if_tb_top.sv
module spi_reg_if_tb_top;
  localparam int NREG = 47;
  localparam int CW   = 7;
  localparam int H    = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, si = 1'b0;
  logic ready = 1'b1;
  logic [2:0] state = 3'd0;
  logic [CW-1:0] rxl = '0, txl = '0;
  logic so;
  logic [NREG*8-1:0] regs;
  logic [7:0] model [NREG];
  int n_chk = 0, n_err = 0;
  bit r4_bad = 0;

  always #10 clk = ~clk;

  spi_reg_if #(.NUM_REGS(NREG), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .si_i(si), .so_o(so),
    .ready_i(ready), .state_i(state), .rx_level_i(rxl), .tx_free_i(txl), .cfg_regs_o(regs)
  );

  function automatic logic [3:0] sat(logic [CW-1:0] v);
    return (v >= 15) ? 4'hF : v[3:0];
  endfunction

  function automatic logic [7:0] st_byte(bit rd);
    return {~ready, state, sat(rd ? rxl : txl)};
  endfunction

  function automatic int nxt(int a);
    return (a >= NREG - 1) ? 0 : a + 1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    int bad = -1;
    for (int r = 0; r < NREG; r++) if (regs[r*8 +: 8] !== model[r] && bad < 0) bad = r;
    n_chk++;
    if (bad >= 0) begin
      n_err++;
      $display("FAIL %s: reg %0d actual %02h expected %02h", req, bad, regs[bad*8 +: 8], model[bad]);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, input bit glitch, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      si = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = so;
      if (glitch && i == 4) begin
        ready = ~ready;
        state = 3'($urandom);
        rxl   = CW'($urandom);
        txl   = CW'($urandom);
      end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (so !== rx[i]) r4_bad = 1;
      sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    csn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_high();
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic txn(bit rd, bit burst, int a0, int n, bit glitch, string htag);
    logic [7:0] rx, exp, d;
    int a;
    cs_low();
    r4_bad = 0;
    exp = st_byte(rd);
    spi_bits({rd, burst, a0[5:0]}, 8, glitch, rx);
    chk(glitch ? "R11" : htag, rx, exp);
    a = a0;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      if (rd) begin
        exp = (a < NREG) ? model[a] : 8'h00;
        spi_bits(d, 8, 0, rx);
        chk(burst ? "R7" : "R6", rx, exp);
      end else begin
        exp = st_byte(0);
        spi_bits(d, 8, 0, rx);
        chk("R5", rx, exp);
        if (a < NREG) model[a] = d;
      end
      if (burst) a = nxt(a);
    end
    cs_high();
    n_chk++;
    if (r4_bad) begin
      n_err++;
      $display("FAIL R4: SO actual changed while SCLK high, expected held");
    end
    chk_regs(rd ? "R6" : ((a0 >= NREG && !burst) ? "R9" : "R5"));
  endtask

  initial begin
    logic [7:0] rx;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREG; r++) model[r] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12", {7'b0, so}, 8'h00);
    chk_regs("R12");

    // R1/R2 status fields and saturation
    ready = 1'b0; state = 3'd4; rxl = 7'd3; txl = 7'd20;
    txn(1, 0, 0, 0, 0, "R1");
    txn(0, 0, 2, 1, 0, "R2");
    ready = 1'b1; state = 3'd1; rxl = 7'd15; txl = 7'd14;
    txn(1, 0, 3, 1, 0, "R2");
    txn(0, 0, 3, 1, 0, "R2");
    state = 3'd7; rxl = 7'd100; txl = 7'd0;
    txn(1, 0, 3, 1, 0, "R2");
    txn(0, 0, 4, 1, 0, "R1");

    // R3 / R8: write then read in one select, second header gives fresh status
    state = 3'd2; rxl = 7'd9; txl = 7'd5;
    cs_low();
    spi_bits({1'b0, 1'b0, 6'h07}, 8, 0, rx); chk("R3", rx, st_byte(0));
    spi_bits(8'hA5, 8, 0, rx);               chk("R5", rx, st_byte(0));
    model[7] = 8'hA5;
    rxl = 7'd11;
    spi_bits({1'b1, 1'b0, 6'h07}, 8, 0, rx); chk("R8", rx, st_byte(1));
    spi_bits(8'h00, 8, 0, rx);               chk("R3", rx, 8'hA5);
    cs_high();
    chk_regs("R8");

    // R7 burst wrap on write and read
    txn(0, 1, 44, 5, 0, "R7");
    txn(1, 1, 45, 4, 0, "R7");
    txn(0, 1, 62, 3, 0, "R7");

    // R9 out-of-range write ignored, R6 out-of-range read is zero
    txn(0, 0, 48, 1, 0, "R9");
    txn(0, 0, 63, 1, 0, "R9");
    txn(1, 0, 63, 1, 0, "R6");
    txn(1, 0, 47, 1, 0, "R6");

    // R10 abort mid data byte and mid header
    cs_low();
    spi_bits({1'b0, 1'b0, 6'h01}, 8, 0, rx);
    spi_bits(8'h3C, 4, 0, rx);
    cs_high();
    chk_regs("R10");
    cs_low();
    spi_bits(8'h00, 3, 0, rx);
    cs_high();
    cs_low();
    spi_bits({1'b1, 1'b0, 6'h01}, 8, 0, rx); chk("R10", rx, st_byte(1));
    spi_bits(8'hFF, 8, 0, rx);               chk("R10", rx, model[1]);
    cs_high();
    chk_regs("R10");

    // R11 inputs change mid header
    txn(1, 0, 7, 1, 1, "R11");
    txn(0, 1, 10, 3, 1, "R11");

    // mixed random traffic
    for (int t = 0; t < 40; t++) begin
      bit rd, bu, gl;
      int a0, n;
      rd = 1'($urandom);
      bu = 1'($urandom);
      gl = ($urandom % 4) == 0;
      a0 = int'($urandom % 64);
      n  = bu ? 1 + int'($urandom % 6) : 1;
      ready = 1'($urandom);
      state = 3'($urandom);
      rxl   = CW'($urandom);
      txl   = CW'($urandom);
      txn(rd, bu, a0, n, gl, "R1/R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule